// File: doc/BRIEF.md
# 8-bit ALU slice with status flags

This block is the arithmetic and logic slice of a small 8-bit controller core. Each clock it takes one 16-bit opcode and decodes it as one of five operations: add, add-with-carry, bitwise AND, AND with an immediate, or arithmetic shift right. The operands are read from a 32-entry register file held inside the block. The 8-bit result is written back to the destination register, and the status register is updated, both at the same clock edge.

The core's other units put data into the register file through a load port. They observe it through an asynchronous read port. The status register is driven out continuously. Any opcode outside the five patterns is a no-operation. The slice has no sequencing states: every accepted opcode finishes at the edge where it is presented, so the only transition is from one executed opcode to the next.

Top module: `alu8_slice`

## Requirements
- R1: While `rst_n` is low, all 32 registers and the status register are cleared to zero.
- R2: An opcode matching `0000 11rd dddd rrrr` adds register r to register d and writes the 8-bit sum to register d. d is opcode bits 8:4. r is opcode bit 9 as its top bit, followed by bits 3:0.
- R3: An opcode matching `0001 11rd dddd rrrr` behaves like R2 but also adds the carry flag (status bit 0) as it stood before the instruction.
- R4: For both additions, status bit 0 (carry) takes the carry out of bit 7. Status bit 3 (overflow) is bit 7 of (res XOR r) AND (res XOR d).
- R5: For both additions, status bit 5 (half-carry) is bit 3 of (d AND r) OR (r AND NOT res) OR (NOT res AND d).
- R6: For every executed operation, status bit 1 (zero) is set exactly when the 8-bit result is 0. Status bit 2 (negative) equals result bit 7. Status bit 4 (sign) equals the new bit 2 XOR the new bit 3.
- R7: An opcode matching `0010 00rd dddd rrrr` writes d AND r to register d. It clears status bit 3 and leaves status bits 0 and 5 unchanged.
- R8: An opcode matching `0111 KKKK dddd KKKK` ANDs register 16+dddd with K. K is built from bits 11:8 (high nibble) and 3:0 (low nibble). Flags follow R7. Registers 0 to 15 are never written by this form.
- R9: An opcode matching `1001 010d dddd 0101` shifts register d right by one while keeping bit 7. Status bit 0 takes the old bit 0 and status bit 3 takes the new bit 2 XOR the new bit 0. Status bit 5 is unchanged.
- R10: An opcode that matches none of the above patterns leaves every register and the status register unchanged.
- R11: Each operation's result and flags are visible one clock edge after the opcode is presented. A `ld_en` pulse writes `ld_data` to `ld_addr` at the next edge, and `rd_data` shows register `rd_addr` without delay. If the load port and the executing operation target the same register in the same cycle, the operation's result is written.
- R12: Status bits 6 and 7 are never changed by any of these operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 16 | Instruction word executed at the next edge |
| ld_en | input | 1 | Register load strobe |
| ld_addr | input | 5 | Register written by the load port |
| ld_data | input | 8 | Data written by the load port |
| rd_addr | input | 5 | Register shown on `rd_data` |
| rd_data | output | 8 | Contents of register `rd_addr` |
| status | output | 8 | Status register |

## Verification
The bench drives carries that ripple only from bit 3, so a design taking the half-carry from the wrong bit reports zero. It also drives a signed overflow from 0x7F+1 and a sum that wraps exactly to zero. A chained add-with-carry consumes a carry left by the previous add; a design that ignores the old carry comes out one low. An immediate AND with a zero register field checks that register 16, not register 0, is written, and that the immediate nibbles are assembled in the right order. Shifts of 0x81 and 0x01 check the kept sign bit and the overflow equal to N XOR C; a design that cleared overflow as the logic operations do fails on these. Unmatched opcodes are checked for leaving both registers and flags alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W  = 8;
    localparam int REG_N   = 32;
    localparam int ADDR_W  = $clog2(REG_N);
    localparam int HALF_B  = DATA_W / 2 - 1;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_ADC  = 3'd2,
        OP_AND  = 3'd3,
        OP_ANDI = 3'd4,
        OP_ASR  = 3'd5
    } alu_op_e;
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [15:0]        opcode,
    output alu_op_e            kind,
    output logic [ADDR_W-1:0]  dst,
    output logic [ADDR_W-1:0]  src,
    output logic [DATA_W-1:0]  imm
);
    logic [ADDR_W-1:0] dst_full;
    logic [ADDR_W-1:0] dst_high;

    assign dst_full = opcode[8:4];
    assign dst_high = {1'b1, opcode[7:4]};
    assign src      = {opcode[9], opcode[3:0]};
    assign imm      = {opcode[11:8], opcode[3:0]};

    always_comb begin
        kind = OP_NONE;
        if (opcode[15:10] == 6'b000011)
            kind = OP_ADD;
        else if (opcode[15:10] == 6'b000111)
            kind = OP_ADC;
        else if (opcode[15:10] == 6'b001000)
            kind = OP_AND;
        else if (opcode[15:12] == 4'b0111)
            kind = OP_ANDI;
        else if (opcode[15:9] == 7'b1001010 && opcode[3:0] == 4'b0101)
            kind = OP_ASR;
    end

    // Immediate form reaches only the upper half of the register file.
    assign dst = (kind == OP_ANDI) ? dst_high : dst_full;
endmodule

// File: rtl/alu8_regfile.sv
module alu8_regfile
    import alu8_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ex_we,
    input  logic [ADDR_W-1:0]  ex_addr,
    input  logic [DATA_W-1:0]  ex_data,
    input  logic               ld_we,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [ADDR_W-1:0]  ra_addr,
    output logic [DATA_W-1:0]  ra_data,
    input  logic [ADDR_W-1:0]  rb_addr,
    output logic [DATA_W-1:0]  rb_data,
    input  logic [ADDR_W-1:0]  rc_addr,
    output logic [DATA_W-1:0]  rc_data
);
    logic [DATA_W-1:0] mem_q [REG_N];

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[gi] <= '0;
            else if (ex_we && ex_addr == ADDR_W'(gi))
                mem_q[gi] <= ex_data;
            else if (ld_we && ld_addr == ADDR_W'(gi))
                mem_q[gi] <= ld_data;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
    assign rc_data = mem_q[rc_addr];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  alu_op_e            kind,
    input  logic [DATA_W-1:0]  opd,
    input  logic [DATA_W-1:0]  ops,
    input  logic [DATA_W-1:0]  sreg_in,
    output logic [DATA_W-1:0]  res,
    output logic               we,
    output logic [DATA_W-1:0]  sreg_out
);
    logic [DATA_W:0]   sum;
    logic              cin;
    logic [DATA_W-1:0] hc_vec;
    logic              f_c, f_v, f_h, f_n;

    assign cin    = (kind == OP_ADC) ? sreg_in[FL_C] : 1'b0;
    assign sum    = {1'b0, opd} + {1'b0, ops} + {{DATA_W{1'b0}}, cin};
    assign hc_vec = (opd & ops) | (ops & ~sum[DATA_W-1:0]) | (~sum[DATA_W-1:0] & opd);

    always_comb begin
        res = '0;
        we  = 1'b1;
        f_c = sreg_in[FL_C];
        f_h = sreg_in[FL_H];
        f_v = sreg_in[FL_V];
        unique case (kind)
            OP_ADD, OP_ADC: begin
                res = sum[DATA_W-1:0];
                f_c = sum[DATA_W];
                f_h = hc_vec[HALF_B];
                f_v = ((res ^ ops) & (res ^ opd)) >> (DATA_W-1) != 0;
            end
            OP_AND, OP_ANDI: begin
                res = opd & ops;
                f_v = 1'b0;
            end
            OP_ASR: begin
                res = {opd[DATA_W-1], opd[DATA_W-1:1]};
                f_c = opd[0];
                f_v = opd[DATA_W-1] ^ opd[0];
            end
            default: begin
                we = 1'b0;
            end
        endcase
    end

    assign f_n = res[DATA_W-1];

    always_comb begin
        sreg_out = sreg_in;
        if (we) begin
            sreg_out[FL_C] = f_c;
            sreg_out[FL_Z] = (res == '0);
            sreg_out[FL_N] = f_n;
            sreg_out[FL_V] = f_v;
            sreg_out[FL_S] = f_n ^ f_v;
            sreg_out[FL_H] = f_h;
        end
    end
endmodule

// File: rtl/alu8_slice.sv
module alu8_slice
    import alu8_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         opcode,
    input  logic                ld_en,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [DATA_W-1:0]   ld_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   status
);
    alu_op_e           op_kind;
    logic [ADDR_W-1:0] dst_a, src_a;
    logic [DATA_W-1:0] imm_k, d_val, r_val, b_val;
    logic [DATA_W-1:0] ex_res, sreg_nx, sreg_q;
    logic              ex_we;

    alu8_decode u_dec (
        .opcode (opcode),
        .kind   (op_kind),
        .dst    (dst_a),
        .src    (src_a),
        .imm    (imm_k)
    );

    alu8_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_we   (ex_we),
        .ex_addr (dst_a),
        .ex_data (ex_res),
        .ld_we   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .ra_addr (dst_a),
        .ra_data (d_val),
        .rb_addr (src_a),
        .rb_data (r_val),
        .rc_addr (rd_addr),
        .rc_data (rd_data)
    );

    assign b_val = (op_kind == OP_ANDI) ? imm_k : r_val;

    alu8_core u_core (
        .kind     (op_kind),
        .opd      (d_val),
        .ops      (b_val),
        .sreg_in  (sreg_q),
        .res      (ex_res),
        .we       (ex_we),
        .sreg_out (sreg_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else
            sreg_q <= sreg_nx;
    end

    assign status = sreg_q;
endmodule

// File: rtl/alu8_slice_chk.sv
module alu8_slice_chk
    import alu8_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  status,
    input alu_op_e            kind,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data
);
    assert_nomatch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_NONE) |=> $stable(status));

    assert_logic_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_AND || kind == OP_ANDI) |=>
        (status[FL_V] == 1'b0 && status[FL_C] == $past(status[FL_C])
         && status[FL_H] == $past(status[FL_H])));

    assert_sign_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[FL_S] == (status[FL_N] ^ status[FL_V]));

    assert_zero_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[FL_Z] == ($past(wr_data) == '0));

    assert_shift_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == OP_ASR) |=> (status[FL_V] == (status[FL_N] ^ status[FL_C])
         && status[FL_H] == $past(status[FL_H])));

    assert_upper_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(status[7:6]));
endmodule

bind alu8_slice alu8_slice_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status),
    .kind    (op_kind),
    .wr_en   (ex_we),
    .wr_data (ex_res)
);

// File: tb/alu8_slice_tb.sv
module alu8_slice_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opcode = 16'h0000;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;
    logic [7:0] m_sreg = 8'h00;

    always #10 clk = ~clk;

    alu8_slice u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
    );

    // kind: 0 add, 1 add-with-carry, 2 and, 3 and-immediate, 4 shift right
    localparam int NV = 12;
    localparam logic [2:0] V_KIND [NV] = '{0, 0, 1, 0, 1, 2, 3, 3, 4, 4, 0, 4};
    localparam logic [4:0] V_D    [NV] = '{1, 3, 5, 7, 9, 10, 16, 31, 4, 30, 12, 0};
    localparam logic [4:0] V_R    [NV] = '{2, 20, 6, 8, 25, 17, 0, 0, 0, 0, 12, 0};
    localparam logic [7:0] V_DV   [NV] = '{8'h0F, 8'h80, 8'h10, 8'h7F, 8'hFF, 8'hF0,
                                           8'hAA, 8'hF0, 8'h81, 8'h02, 8'h40, 8'h01};
    localparam logic [7:0] V_RV   [NV] = '{8'h01, 8'h80, 8'h20, 8'h01, 8'h01, 8'h3C,
                                           8'h80, 8'h0F, 8'h00, 8'h00, 8'h40, 8'h00};
    localparam logic [7:0] V_EXP  [NV] = '{8'h10, 8'h00, 8'h31, 8'h80, 8'h00, 8'h30,
                                           8'h80, 8'h00, 8'hC0, 8'h01, 8'h80, 8'h00};

    function automatic logic [15:0] enc(input logic [2:0] k, input logic [4:0] d,
                                        input logic [4:0] r, input logic [7:0] kv);
        case (k)
            3'd0: enc = {6'b000011, r[4], d, r[3:0]};
            3'd1: enc = {6'b000111, r[4], d, r[3:0]};
            3'd2: enc = {6'b001000, r[4], d, r[3:0]};
            3'd3: enc = {4'b0111, kv[7:4], d[3:0], kv[3:0]};
            default: enc = {7'b1001010, d, 4'b0101};
        endcase
    endfunction

    // Reference model: returns {result, new status}
    function automatic logic [15:0] model(input logic [2:0] k, input logic [7:0] dv,
                                          input logic [7:0] rv, input logic [7:0] s);
        logic [8:0] sm;
        logic [7:0] res, ns;
        ns = s;
        if (k <= 3'd1) begin
            sm  = dv + rv + ((k == 3'd1) ? {8'd0, s[0]} : 9'd0);
            res = sm[7:0];
            ns[0] = sm[8];
            ns[3] = (res[7] ^ rv[7]) & (res[7] ^ dv[7]);
            ns[5] = (dv[3] & rv[3]) | (rv[3] & ~res[3]) | (~res[3] & dv[3]);
        end else if (k <= 3'd3) begin
            res = dv & rv;
            ns[3] = 1'b0;
        end else begin
            res = {dv[7], dv[7:1]};
            ns[0] = dv[0];
            ns[3] = res[7] ^ dv[0];
        end
        ns[1] = (res == 8'h00);
        ns[2] = res[7];
        ns[4] = ns[2] ^ ns[3];
        model = {res, ns};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run(input logic [15:0] op);
        @(negedge clk);
        opcode = op;
        @(negedge clk);
        opcode = 16'h0000;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  v;
        logic [15:0] mr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 8'h00);
        peek(5'd0, v);  chk("R1 r0", v, 8'h00);
        peek(5'd31, v); chk("R1 r31", v, 8'h00);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11 R12
        for (int i = 0; i < NV; i++) begin
            load(V_D[i], V_DV[i]);
            if (V_KIND[i] <= 3'd2 && V_R[i] != V_D[i]) load(V_R[i], V_RV[i]);
            mr = model(V_KIND[i], V_DV[i], V_RV[i], m_sreg);
            chk("R11 model-table agree", mr[15:8], V_EXP[i]);
            run(enc(V_KIND[i], V_D[i], V_R[i], V_RV[i]));
            m_sreg = mr[7:0];
            peek(V_D[i], v);
            chk("R2/R3/R7/R8/R9 result", v, V_EXP[i]);
            chk("R4/R5/R6/R12 status", status, m_sreg);
        end

        // R2: source register unchanged by add
        load(5'd2, 8'h05); load(5'd1, 8'h03);
        run(enc(3'd0, 5'd1, 5'd2, 8'h00));
        m_sreg = model(3'd0, 8'h03, 8'h05, m_sreg);
        peek(5'd2, v); chk("R2 source kept", v, 8'h05);
        peek(5'd1, v); chk("R2 sum", v, 8'h08);

        // R8: field 0 targets r16, r0 untouched
        load(5'd0, 8'h5A); load(5'd16, 8'hFF);
        run(enc(3'd3, 5'd16, 5'd0, 8'h3C));
        peek(5'd16, v); chk("R8 r16 written", v, 8'h3C);
        peek(5'd0, v);  chk("R8 r0 untouched", v, 8'h5A);

        // R10: unmatched opcodes change nothing
        v = status;
        run(16'hFFFF);
        chk("R10 status after FFFF", status, v);
        run(16'h9406);
        chk("R10 status after 9406", status, v);
        peek(5'd16, v); chk("R10 r16 kept", v, 8'h3C);

        // R11: operation wins over load on same register
        load(5'd20, 8'h11);
        @(negedge clk);
        opcode = enc(3'd4, 5'd20, 5'd0, 8'h00);
        ld_en = 1'b1; ld_addr = 5'd20; ld_data = 8'hEE;
        @(negedge clk);
        opcode = 16'h0000; ld_en = 1'b0;
        peek(5'd20, v); chk("R11 collision", v, 8'h08);

        // R1: reset in mid-run clears again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 status after reset", status, 8'h00);
        peek(5'd20, v); chk("R1 r20 after reset", v, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule